// File: doc/BRIEF.md
# Duplex-Based Binary Squarer

This block squares an unsigned operand of N bits, where N is a parameter, and returns the full 2N-bit product. It is purely combinational. It does not build a general multiplier array. Instead, each result column gets a duplex value: every off-diagonal pair of operand bits whose positions add up to that column's weight is formed once and counted twice. If the column weight is even, the single bit at half that weight is added as the middle term. A bit times itself is the bit itself, so that middle term needs no AND gate.

There are 2N−1 duplex columns. A carry chain resolves them, starting at the least significant column and working upward. At each column the duplex and the incoming carry are added. The low bit of that sum becomes the result bit, and the remaining bits are passed up as a carry that may be several bits wide. The carry out of the top column is the most significant result bit. The block has no clock, no state and no handshake. A wrapping design registers the operand and the square if it needs timing isolation.

No state machine is present, so no states or transitions exist to name. The only structure is the column array feeding the carry chain.

Top module: `dsq_squarer`

## Requirements
- R1: For the default width N=8, `square` equals `operand*operand` for every one of the 256 operand values.
- R2: Bit 0 of `square` always equals bit 0 of `operand`.
- R3: Bit 1 of `square` is always 0.
- R4: An all-zero operand gives an all-zero square. An all-ones operand gives 2^(2N) − 2^(N+1) + 1. For N=8 that is 0xFE01, which is the largest value the carry chain ever has to carry into the top bit.
- R5: For N=4, operand 4'b1001 gives square 8'b01010001.
- R6: The width parameter is honoured for both even and odd N. For N=4 and N=5, every operand value gives exactly `operand*operand`.
- R7: An operand with a single bit set at position k gives a single bit set at position 2k. This exercises the middle-bit term alone.
- R8: An operand with exactly two bits set, at positions i and j with i<j, gives 2^(2i) + 2^(2j) + 2^(i+j+1). This exercises the doubled off-diagonal pair.
- R9: The block is combinational: after the operand changes, `square` reflects the new value without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand | input | N | Unsigned value to be squared |
| square | output | 2N | Unsigned square of `operand` |

## Verification
Exhaustive sweeps at N=8, N=4 and N=5 establish exact equality with the arithmetic product. The odd width separates correct handling of the middle bit from an even-only assumption. Single-bit operands isolate the middle-bit term, because no pair term is active. Two-bit operands isolate one doubled pair, so a missing doubling or a pair counted twice shows up as a wrong bit at position i+j or i+j+1. The all-ones operand drives the widest carries through the chain. Fixed checks of the two lowest result bits catch column misalignment at the bottom of the chain.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

    // Width needed for one column's duplex: at most N/2 doubled pairs plus one middle bit.
    function automatic int dup_width(input int n);
        return $clog2(n + 1) + 1;
    endfunction

    // Width of the running column sum: the duplex plus the incoming carry stays at or below 2N.
    function automatic int acc_width(input int n);
        return $clog2(2 * n + 2) + 1;
    endfunction

endpackage

// File: rtl/dsq_column.sv
module dsq_column
    import dsq_pkg::*;
#(
    parameter int N   = 8,
    parameter int COL = 0
) (
    input  logic [N-1:0]              operand,
    output logic [dup_width(N)-1:0]   duplex
);
    localparam int DW = dup_width(N);

    logic [DW-1:0] pair_sum;
    logic          mid_bit;

    // Each off-diagonal pair (i<j) with i+j == COL is formed exactly once.
    always_comb begin
        pair_sum = '0;
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                if (i + j == COL) begin
                    pair_sum = pair_sum + DW'(operand[i] & operand[j]);
                end
            end
        end
    end

    // The middle term: a bit squared is the bit itself.
    always_comb begin
        mid_bit = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (2 * i == COL) begin
                mid_bit = operand[i];
            end
        end
    end

    // Doubling the pair sum is a shift by one place.
    assign duplex = (pair_sum << 1) + DW'(mid_bit);

    // R1: the duplex never exceeds N, so the carry chain's width bound holds
    always_comb begin
        a_r1_duplex_bound: assert (int'(duplex) <= N)
            else $error("duplex column %0d out of range: %0d", COL, duplex);
    end

endmodule

// File: rtl/dsq_carry_chain.sv
module dsq_carry_chain
    import dsq_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [(2*N-1)*dup_width(N)-1:0] dup_bus,
    output logic [2*N-1:0]                  result
);
    localparam int DW   = dup_width(N);
    localparam int AW   = acc_width(N);
    localparam int COLS = 2 * N - 1;

    logic [AW-1:0] carry [0:COLS];

    assign carry[0] = '0;

    // Resolve the columns from the least significant one upward; carries may span several bits.
    for (genvar c = 0; c < COLS; c++) begin : g_stage
        logic [AW-1:0] acc;
        assign acc          = AW'(dup_bus[c*DW +: DW]) + carry[c];
        assign result[c]    = acc[0];
        assign carry[c+1]   = acc >> 1;
    end

    // The carry out of the top column becomes the most significant result bit.
    assign result[2*N-1] = carry[COLS][0];

    // R1: the top carry fits one bit, so no part of the square is lost
    always_comb begin
        a_r1_top_carry_fits: assert (carry[COLS] < AW'(2))
            else $error("top carry too wide: %0d", carry[COLS]);
    end

endmodule

// File: rtl/dsq_squarer.sv
module dsq_squarer
    import dsq_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]   operand,
    output logic [2*N-1:0] square
);
    localparam int DW   = dup_width(N);
    localparam int COLS = 2 * N - 1;

    logic [COLS*DW-1:0] dup_bus;

    for (genvar c = 0; c < COLS; c++) begin : g_col
        dsq_column #(
            .N   (N),
            .COL (c)
        ) u_col (
            .operand (operand),
            .duplex  (dup_bus[c*DW +: DW])
        );
    end

    dsq_carry_chain #(
        .N (N)
    ) u_chain (
        .dup_bus (dup_bus),
        .result  (square)
    );

    // R2: the lowest result bit follows the lowest operand bit
    always_comb begin
        a_r2_lsb_match: assert (square[0] == operand[0])
            else $error("square bit 0 mismatch");
    end

    // R3: a square is never 2 or 3 modulo 4
    always_comb begin
        a_r3_bit1_zero: assert (square[1] == 1'b0)
            else $error("square bit 1 set");
    end

endmodule

// File: tb/dsq_squarer_test.sv
module dsq_squarer_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [7:0]  op8 = '0;
    logic [15:0] sq8;
    logic [3:0]  op4 = '0;
    logic [7:0]  sq4;
    logic [4:0]  op5 = '0;
    logic [9:0]  sq5;

    dsq_squarer #(.N(8)) uut    (.operand(op8), .square(sq8));
    dsq_squarer #(.N(4)) uut_n4 (.operand(op4), .square(sq4));
    dsq_squarer #(.N(5)) uut_n5 (.operand(op5), .square(sq5));

    int n_checks = 0;
    int n_fails  = 0;
    bit driving_done = 0;

    // Scoreboard queues: which instance, which field, expected value, requirement tag.
    int      q_dut[$];
    int      q_kind[$];   // 0 = full square, 1 = bit 0, 2 = bit 1
    longint  q_exp[$];
    string   q_req[$];

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic push(input int dut, input int kind, input longint exp, input string req);
        q_dut.push_back(dut);
        q_kind.push_back(kind);
        q_exp.push_back(exp);
        q_req.push_back(req);
    endtask

    // Drives one operand on the given instance at a rising edge and records the expectation.
    task automatic drive(input int dut, input longint val, input string req);
        @(posedge clk);
        case (dut)
            8: op8 = val[7:0];
            4: op4 = val[3:0];
            default: op5 = val[4:0];
        endcase
        push(dut, 0, val * val, req);
    endtask

    // Monitor: at each falling edge, compares the oldest expected item with the outputs.
    initial begin
        forever begin
            @(negedge clk);
            if (q_dut.size() != 0) begin
                automatic int     d = q_dut.pop_front();
                automatic int     k = q_kind.pop_front();
                automatic longint e = q_exp.pop_front();
                automatic string  r = q_req.pop_front();
                automatic longint a;
                case (d)
                    8: a = longint'(sq8);
                    4: a = longint'(sq4);
                    default: a = longint'(sq5);
                endcase
                if (k == 1) a = a & 1;
                if (k == 2) a = (a >> 1) & 1;
                check(r, a, e);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: operand zero gives zero square (R4)
        @(negedge clk);
        check("R4 zero after reset", longint'(sq8), 0);

        // R1: exhaustive N=8, plus R2 and R3 on every vector
        for (int v = 0; v < 256; v++) begin
            drive(8, v, "R1");
            push(8, 1, v & 1, "R2");
            push(8, 2, 0, "R3");
            @(posedge clk);
            @(posedge clk);
        end

        // R4: corner operands
        drive(8, 0, "R4 zero");
        drive(8, 255, "R4 all ones");
        drive(4, 15, "R4 all ones N=4");

        // R5: the worked example
        drive(4, 9, "R5");

        // R6: exhaustive at N=4 and odd N=5
        for (int v = 0; v < 16; v++) drive(4, v, "R6 N=4");
        for (int v = 0; v < 32; v++) drive(5, v, "R6 N=5");

        // R7: single-bit operands
        for (int k = 0; k < 8; k++) drive(8, longint'(1) << k, "R7");

        // R8: two-bit operands, expectation computed from the pair formula
        for (int i = 0; i < 8; i++) begin
            for (int j = i + 1; j < 8; j++) begin
                @(posedge clk);
                op8 = 8'((1 << i) | (1 << j));
                push(8, 0, (longint'(1) << (2*i)) + (longint'(1) << (2*j))
                           + (longint'(1) << (i + j + 1)), "R8");
            end
        end

        // Let the monitor drain
        while (q_dut.size() != 0) @(posedge clk);
        @(posedge clk);

        // R9: no clock edge between operand change and observation
        @(negedge clk);
        op8 = 8'd13;
        #0.5;
        check("R9", longint'(sq8), 169);
        op8 = 8'd200;
        #0.5;
        check("R9", longint'(sq8), 40000);

        driving_done = 1;
    end

    initial begin
        fork
            wait (driving_done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule